// File: doc/BRIEF.md
# SDRAM Descriptor-List Transfer Engine

This engine moves blocks of data between a 32-bit synchronous system memory and a 16-bit single-data-rate SDRAM. The work to do is not handed over on a request port. It is described by a list of two-word descriptors held in the system memory. The engine walks the list from a base address. It performs each pending descriptor as one full-page burst, either a write into the SDRAM or a read from it. When a transfer completes, the engine clears the descriptor's first word so that software can see the transfer is finished.

A first word of zero is skipped. A first word of 8 ends the list, and the engine returns to the base address. Software can therefore post new work at any time by writing the second word of a slot and then its first word. Before each descriptor, and again on every pass through the list, the engine precharges all banks, reloads the mode register and issues an auto-refresh. After reset it keeps the SDRAM idle for a power-up interval before sending any command. Each 32-bit memory word maps onto two consecutive SDRAM beats, low half first.

Top module: `sdram_list_engine`

## Requirements
- R1: After reset, cke is high and the chip select is high (deselect) for exactly PWR_CYC clock cycles. The first command issued is precharge-all.
- R2: Descriptor word 0 holds the system-memory byte address in bits 31..4, a write flag in bit 3 (1 means memory to SDRAM) and a size code c in bits 2..0. Codes 1..7 move 2^(c-1) quads of 16 bytes, that is 8·2^(c-1) SDRAM beats. Word 1 bits 24..0 hold the SDRAM byte address.
- R3: A word 0 of 0 is skipped. A word 0 of 8 sends the engine back to list_base, so descriptors placed after the end marker never run. A slot that is filled after the end marker has been passed is executed on the next pass.
- R4: When a transfer completes, the engine writes 0 to that descriptor's word 0, in the cycle after burst-terminate. Word 1 is left unchanged.
- R5: Each descriptor's activate is preceded, in this order, by precharge-all (a[10]=1), load-mode and auto-refresh. Every command is followed by at least one deselect cycle. The spacings PRE→MRS, MRS→REF, REF→ACT and ACT→READ/WRITE are at least T_RP+1, T_MRD+1, T_RFC+1 and T_RCD+1 cycles.
- R6: Load-mode drives bank 0 and address 0x037, which selects full-page bursts, sequential order and CAS latency 3.
- R7: Activate drives bank = address bits 24..23 and row = address bits 22..10. Read and write drive the same bank and a = {4'b0, address bits 9..1}.
- R8: A write puts memory word k on dq as beat 2k (bits 15..0) and beat 2k+1 (bits 31..16). Beat 0 is driven in the write-command cycle, and the following beats are driven in back-to-back cycles. Burst-terminate follows the last beat, and dq is released in that same cycle, so no beat beyond the size is written.
- R9: During reads the engine never drives dq. Beat n is taken from dq at the clock edge CAS_LAT+1+n cycles after the read-command cycle. The beats are stored little-endian into consecutive memory words, and no word past the block is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| list_base | input | MAW+2 | Byte address of the first descriptor |
| mem_addr | output | MAW | System memory word address |
| mem_we | output | 1 | System memory write enable |
| mem_wdata | output | 32 | System memory write data |
| mem_rdata | input | 32 | System memory read data, one cycle after the address |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_ba | output | 2 | SDRAM bank address |
| sd_a | output | 13 | SDRAM row/column address |
| sd_dq | inout | 16 | SDRAM data bus |

## Verification
Each result falls due at a fixed cycle:
- The first command is due PWR_CYC+1 edges after reset is released.
- Write beats are sampled at the write-command edge and at every following edge up to burst-terminate.
- Read beat n must be on dq at the edge CAS_LAT+1+n cycles after the read-command cycle.
- The done marker is written in the cycle after burst-terminate.

The SDRAM model in the bench acts on every rising edge at these exact offsets, with CAS latency 3. A read-capture slip of one cycle therefore shifts every halfword, and a short or long burst leaves a missing or an extra SDRAM word. Completion is polled on falling edges with a bounded wait, after which the data, the guard words past each block and the descriptor words are compared against values computed arithmetically.

// File: rtl/sdram_list_engine.sv
module sdram_list_engine #(
  parameter int MAW     = 12,
  parameter int PWR_CYC = 6000,
  parameter int T_RP    = 3,
  parameter int T_MRD   = 2,
  parameter int T_RFC   = 8,
  parameter int T_RCD   = 3,
  parameter int CAS_LAT = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [MAW+1:0] list_base,
  output logic [MAW-1:0] mem_addr,
  output logic           mem_we,
  output logic [31:0]    mem_wdata,
  input  logic [31:0]    mem_rdata,
  output logic           sd_cke,
  output logic           sd_cs_n,
  output logic           sd_ras_n,
  output logic           sd_cas_n,
  output logic           sd_we_n,
  output logic [1:0]     sd_ba,
  output logic [12:0]    sd_a,
  inout  wire  [15:0]    sd_dq
);
  localparam int CW = $clog2(PWR_CYC + 1100 + CAS_LAT + T_RP + T_MRD + T_RFC + T_RCD);
  localparam logic [3:0] C_NOP = 4'b1111, C_PRE = 4'b0010, C_MRS = 4'b0000, C_REF = 4'b0001,
                         C_ACT = 4'b0011, C_WR  = 4'b0100, C_RD  = 4'b0101, C_BST = 4'b0110;

  typedef enum logic [4:0] {S_PWR, S_PRE, S_MRS, S_REF, S_WAIT, S_RD0, S_CHK0, S_RD1, S_CHK1,
                            S_ACT, S_WPF, S_WLD, S_WCMD, S_WBURST, S_RCMD, S_RDAT, S_BST, S_DONE} st_t;

  st_t            st, ret;
  logic [CW-1:0]  cnt, bi;
  logic [MAW-1:0] ptr, hubw;
  logic           wr;
  logic [9:0]     nbeat;
  logic [24:1]    sa;
  logic [31:0]    wbuf;
  logic [15:0]    din_q, lo_q;
  logic [3:0]     cmd, prev_cmd;
  logic           oe, cap;
  logic           unused_bits;

  assign unused_bits = ^{mem_rdata, list_base[1:0]};
  assign sd_cke   = 1'b1;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign oe    = (st == S_WCMD) || (st == S_WBURST);
  assign sd_dq = oe ? (cnt[0] ? wbuf[31:16] : wbuf[15:0]) : 'z;
  assign bi    = cnt - CW'(CAS_LAT + 1);
  assign cap   = (st == S_RDAT) && (cnt >= CW'(CAS_LAT + 1));

  always_comb begin
    cmd = C_NOP; sd_ba = '0; sd_a = '0;
    mem_addr = hubw; mem_we = 1'b0; mem_wdata = {din_q, lo_q};
    case (st)
      S_PRE:  begin cmd = C_PRE; sd_a[10] = 1'b1; end
      S_MRS:  begin cmd = C_MRS; sd_a = 13'h037; end
      S_REF:  cmd = C_REF;
      S_ACT:  begin cmd = C_ACT; sd_ba = sa[24:23]; sd_a = sa[22:10]; end
      S_WCMD: begin cmd = C_WR;  sd_ba = sa[24:23]; sd_a = {4'b0, sa[9:1]}; end
      S_RCMD: begin cmd = C_RD;  sd_ba = sa[24:23]; sd_a = {4'b0, sa[9:1]}; end
      S_BST:  cmd = C_BST;
      S_RD0:  mem_addr = ptr;
      S_RD1:  mem_addr = ptr + MAW'(1);
      S_RDAT: mem_we = cap && bi[0];
      S_DONE: begin mem_addr = ptr; mem_we = 1'b1; mem_wdata = '0; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) din_q <= sd_dq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_PWR; ret <= S_PRE; cnt <= CW'(PWR_CYC - 1);
      ptr <= list_base[MAW+1:2]; hubw <= '0; wr <= 1'b0; nbeat <= '0;
      sa <= '0; wbuf <= '0; lo_q <= '0;
    end else begin
      case (st)
        S_PWR:  if (cnt == '0) st <= S_PRE; else cnt <= cnt - CW'(1);
        S_PRE:  begin st <= S_WAIT; cnt <= CW'(T_RP - 1);  ret <= S_MRS; end
        S_MRS:  begin st <= S_WAIT; cnt <= CW'(T_MRD - 1); ret <= S_REF; end
        S_REF:  begin st <= S_WAIT; cnt <= CW'(T_RFC - 1); ret <= S_RD0; end
        S_WAIT: if (cnt == '0) st <= ret; else cnt <= cnt - CW'(1);
        S_RD0:  st <= S_CHK0;
        S_CHK0: begin
          if (mem_rdata == '0) begin
            ptr <= ptr + MAW'(2); st <= S_RD0;
          end else if (mem_rdata[2:0] == 3'd0) begin
            ptr <= list_base[MAW+1:2]; st <= S_PRE;
          end else begin
            wr    <= mem_rdata[3];
            hubw  <= {mem_rdata[MAW+1:4], 2'b00};
            nbeat <= 10'((10'd8 << (mem_rdata[2:0] - 3'd1)) - 10'd1);
            st    <= S_RD1;
          end
        end
        S_RD1:  st <= S_CHK1;
        S_CHK1: begin sa <= mem_rdata[24:1]; st <= S_ACT; end
        S_ACT:  begin st <= S_WAIT; cnt <= CW'(T_RCD - 1); ret <= wr ? S_WPF : S_RCMD; end
        S_WPF:  st <= S_WLD;
        S_WLD:  begin wbuf <= mem_rdata; hubw <= hubw + MAW'(1); cnt <= '0; st <= S_WCMD; end
        S_WCMD, S_WBURST: begin
          if (cnt[0]) wbuf <= mem_rdata; else hubw <= hubw + MAW'(1);
          if (cnt == CW'(nbeat)) st <= S_BST;
          else begin cnt <= cnt + CW'(1); st <= S_WBURST; end
        end
        S_RCMD: begin cnt <= CW'(1); st <= S_RDAT; end
        S_RDAT: begin
          cnt <= cnt + CW'(1);
          if (cap) begin
            if (bi[0]) hubw <= hubw + MAW'(1); else lo_q <= din_q;
            if (bi == CW'(nbeat)) st <= S_BST;
          end
        end
        S_BST:  st <= S_DONE;
        S_DONE: begin ptr <= ptr + MAW'(2); st <= S_PRE; end
        default: st <= S_PRE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_cmd <= C_NOP;
    else if (!cmd[3]) prev_cmd <= cmd;
  end

  a_r1_quiet_powerup: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PWR) |-> (sd_cs_n && sd_cke));
  a_r5_deselect_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cs_n |=> sd_cs_n);
  a_r5_mrs_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_MRS) |-> (prev_cmd == C_PRE));
  a_r5_ref_after_mrs: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_REF) |-> (prev_cmd == C_MRS));
  a_r5_act_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT) |-> (prev_cmd == C_REF));
  a_r8_release_on_bst: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe) |-> (cmd == C_BST));
  a_r8_drive_only_write: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> (cmd == C_WR || prev_cmd == C_WR));
  a_r9_read_bus_free: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_cmd == C_RD) |-> !oe);
  a_r4_done_after_bst: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_BST) |=> (mem_we && mem_wdata == 32'd0));
endmodule

// File: tb/sim_sdram_list_engine.sv
module sim_sdram_list_engine;
  localparam int MAW = 12, PWR = 40, TRP = 3, TMRD = 2, TRFC = 8, TRCD = 3;
  localparam logic [3:0] C_PRE = 4'b0010, C_MRS = 4'b0000, C_REF = 4'b0001,
                         C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101, C_BST = 4'b0110;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [MAW-1:0] mem_addr;
  logic mem_we;
  logic [31:0] mem_wdata, mem_rdata;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0] sd_ba;
  logic [12:0] sd_a;
  wire  [15:0] sd_dq;

  sdram_list_engine #(.MAW(MAW), .PWR_CYC(PWR), .T_RP(TRP), .T_MRD(TMRD), .T_RFC(TRFC),
                      .T_RCD(TRCD), .CAS_LAT(3)) u0 (
    .clk(clk), .rst_n(rst_n), .list_base('0), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
    .sd_a(sd_a), .sd_dq(sd_dq));

  // system memory with a host write port
  logic [31:0] mem [0:4095];
  logic h_we = 0;
  logic [MAW-1:0] h_addr = '0;
  logic [31:0] h_data = '0;
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (h_we) mem[h_addr] <= h_data;
    mem_rdata <= mem[mem_addr];
  end

  function automatic int src_w(int c); return 1024 + 8 * ((1 << (c - 1)) - 1); endfunction
  function automatic int dst_w(int c); return 2048 + 8 * ((1 << (c - 1)) - 1); endfunction
  function automatic int sa_of(int c); return ((c & 3) << 23) | (c << 10); endfunction
  function automatic logic [31:0] pat(int i); return {16'(i * 7 + 3), 16'(i ^ 16'h5A5A)}; endfunction
  function automatic logic [31:0] init_word(int i);
    int s, h, c;
    s = i / 2; h = i % 2;
    if (i < 34) begin
      if (s < 7) begin c = s + 1; return h ? 32'(sa_of(c)) : 32'(src_w(c) * 4 + 8 + c); end
      if (s == 7) return h ? 32'h1234 : 32'd0;
      if (s < 15) begin c = s - 7; return h ? 32'(sa_of(c)) : 32'(dst_w(c) * 4 + c); end
      if (s == 15) return h ? 32'd0 : 32'd8;
      return h ? 32'((3 << 23) | (100 << 10)) : 32'(src_w(3) * 4 + 8 + 1);
    end
    if (i >= 1024 && i < 1784) return pat(i);
    return 32'hC0DE0000 | 32'(i);
  endfunction

  // behavioural SDRAM, CAS latency 3
  logic [15:0] sdm [int];
  logic [12:0] open_row [0:3];
  logic [1:0] mbank;
  logic [8:0] mcol;
  logic wr_on, rd_on, seen, drv_en;
  logic [15:0] drv_val;
  logic [3:0] last;
  int rd_dly, cyc, last_cyc, pwr_cnt, m_checks, m_errs;
  assign sd_dq = drv_en ? drv_val : 'z;

  task automatic mchk(input bit ok, input string msg, input int act, input int exp);
    m_checks++;
    if (!ok) begin m_errs++; $display("FAIL %s: actual %0d expected %0d", msg, act, exp); end
  endtask

  function automatic int key(logic [1:0] b, logic [8:0] col);
    return int'({b, open_row[b], col});
  endfunction

  initial begin m_checks = 0; m_errs = 0; end
  always @(posedge clk) begin
    logic [3:0] cmd;
    int gap, k;
    cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (!rst_n) begin
      wr_on = 0; rd_on = 0; seen = 0; drv_en <= 0; cyc = 0; last_cyc = 0; pwr_cnt = 0; last = 4'hF;
    end else begin
      cyc++;
      if (!seen && sd_cs_n) pwr_cnt++;
      if (rd_on) begin
        if (rd_dly > 1) rd_dly--;
        else begin
          k = key(mbank, mcol);
          drv_en <= 1; drv_val <= sdm.exists(k) ? sdm[k] : 16'h0BAD; mcol++;
        end
      end
      if (wr_on && sd_cs_n) begin sdm[key(mbank, mcol)] = sd_dq; mcol++; end
      if (!sd_cs_n) begin
        gap = cyc - last_cyc;
        if (!seen) begin
          seen = 1;
          mchk(pwr_cnt == PWR, "R1 idle cycles before first command", pwr_cnt, PWR);
          mchk(cmd == C_PRE, "R1 first command is precharge", int'(cmd), int'(C_PRE));
        end else mchk(gap >= 2, "R5 deselect after each command", gap, 2);
        case (cmd)
          C_PRE: begin
            mchk(sd_a[10], "R5 precharge-all a10", int'(sd_a[10]), 1);
            wr_on = 0; rd_on = 0; drv_en <= 0;
          end
          C_MRS: begin
            mchk(last == C_PRE && gap >= TRP + 1, "R5 PRE->MRS order/gap", gap, TRP + 1);
            mchk({sd_ba, sd_a} == 15'h037, "R6 mode value", int'({sd_ba, sd_a}), 'h37);
          end
          C_REF: mchk(last == C_MRS && gap >= TMRD + 1, "R5 MRS->REF order/gap", gap, TMRD + 1);
          C_ACT: begin
            mchk(last == C_REF && gap >= TRFC + 1, "R5 REF->ACT order/gap", gap, TRFC + 1);
            open_row[sd_ba] = sd_a;
          end
          C_WR, C_RD: begin
            mchk(last == C_ACT && gap >= TRCD + 1, "R5 ACT->RD/WR order/gap", gap, TRCD + 1);
            mchk(sd_a[12:9] == 0, "R7 column upper lines zero", int'(sd_a[12:9]), 0);
            mbank = sd_ba; mcol = sd_a[8:0];
            if (cmd == C_WR) begin sdm[key(mbank, mcol)] = sd_dq; mcol++; wr_on = 1; end
            else begin rd_on = 1; rd_dly = 2; end
          end
          C_BST: begin wr_on = 0; rd_on = 0; drv_en <= 0; end
          default: ;
        endcase
        last = cmd; last_cyc = cyc;
      end
    end
  end

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string msg, input longint act, input longint exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s: actual %0h expected %0h", msg, act, exp); end
  endtask

  task automatic hwrite(input int a, input logic [31:0] d);
    @(negedge clk); h_we = 1; h_addr = MAW'(a); h_data = d;
    @(negedge clk); h_we = 0;
  endtask

  task automatic check_sd(input int words, input int sw, input int sa, input string tag);
    int bad = 0, base = sa >>> 1;
    for (int k = 0; k < words; k++) begin
      if (!sdm.exists(base + 2 * k) || sdm[base + 2 * k] !== pat(sw + k)[15:0]) bad++;
      if (!sdm.exists(base + 2 * k + 1) || sdm[base + 2 * k + 1] !== pat(sw + k)[31:16]) bad++;
    end
    chk(bad == 0, {tag, " SDRAM halfwords mismatched"}, bad, 0);
    chk(!sdm.exists(base + 2 * words), {tag, " no beat past burst"}, sdm.exists(base + 2 * words), 0);
  endtask

  initial begin
    int waited, pend, w, bad;
    for (int i = 0; i < 4096; i++) begin
      @(negedge clk); h_we = 1; h_addr = MAW'(i); h_data = init_word(i);
    end
    @(negedge clk); h_we = 0;
    chk(sd_cke == 1 && sd_cs_n == 1, "R1 outputs in reset", {sd_cke, sd_cs_n}, 2'b11);
    rst_n = 1;
    waited = 0;
    do begin
      @(negedge clk); waited++; pend = 0;
      for (int s = 0; s < 15; s++) if (mem[2 * s] != 0) pend++;
    end while (pend != 0 && waited < 60000);
    chk(pend == 0, "R4 all descriptors marked done", pend, 0);
    for (int s = 0; s < 15; s++)
      chk(mem[2 * s + 1] == init_word(2 * s + 1), "R4 word 1 unchanged", mem[2 * s + 1], init_word(2 * s + 1));
    for (int c = 1; c <= 7; c++) begin
      w = 4 << (c - 1);
      check_sd(w, src_w(c), sa_of(c), "R8 R2 write");
      bad = 0;
      for (int k = 0; k < w; k++) if (mem[dst_w(c) + k] !== pat(src_w(c) + k)) bad++;
      chk(bad == 0, "R9 R7 read-back words mismatched", bad, 0);
      chk(mem[dst_w(c) + w] == (32'hC0DE0000 | 32'(dst_w(c) + w)), "R9 guard word past block",
          mem[dst_w(c) + w], 32'hC0DE0000 | 32'(dst_w(c) + w));
    end
    // post new work into the skipped slot after the list has wrapped
    hwrite(15, 32'((1 << 23) | (200 << 10)));
    hwrite(14, 32'(src_w(5) * 4 + 8 + 1));
    waited = 0;
    do begin @(negedge clk); waited++; end while (mem[14] != 0 && waited < 20000);
    chk(mem[14] == 0, "R3 slot filled after wrap runs", mem[14], 0);
    check_sd(4, src_w(5), (1 << 23) | (200 << 10), "R3 posted write");
    chk(mem[32] == init_word(32), "R3 descriptor after end marker untouched", mem[32], init_word(32));
    chk(!sdm.exists(((3 << 23) | (100 << 10)) >>> 1), "R3 no transfer after end marker",
        sdm.exists(((3 << 23) | (100 << 10)) >>> 1), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks + m_checks, errors + m_errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog R3 list progress: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks + m_checks + 1, errors + m_errs + 1);
    $finish;
  end
endmodule